// File: doc/BRIEF.md
# Paired Sample-Hold Conversion Sequencer

This block runs conversion sequences for eight analog channels split into two groups of four. Channels 0 to 3 (group A) and channels 4 to 7 (group B) each pass through their own sample-hold path. One channel from each group is held at the same instant, so the eight channels are converted as four simultaneous pairs. The converter is external. It has a fixed pipeline latency and one result bus. The block tells it when to hold which pair, then takes the results off the bus and places each one in that channel's 14-bit register.

A converter clock enable is derived from the system clock by an integer divisor. Software, the rising edge of an external pin or a timer event can start a sequence, and the host chooses which of them is used. When the last result of a sequence has been stored, the block raises a one-cycle completion pulse. That pulse goes either to the interrupt side or to a DMA request line. A code at either end of the scale sets a sticky out-of-range flag for that channel. A start that comes in during a running sequence sets a sticky overrun flag.

Top module: `adc_pair_sequencer`

## Requirements
- R1: During and after reset, every result register reads 0, and `oor_flags`, `overrun`, `busy`, `done_irq` and `dma_req` read 0.
- R2: `src_sel` picks the start source: 0 = a one-cycle `sw_start` pulse, 1 = a rising edge of `ext_start` (compared with its value one cycle earlier), 2 = a one-cycle `tmr_evt` pulse, 3 = no start. The two sources that are not selected have no effect on `busy`.
- R3: `conv_tick` is high for one cycle in every D cycles. D is `div_sel` limited to the range 4..30. D is captured in the cycle a start is accepted, and the first tick comes D cycles after that cycle. `adc_clk` is high for the first floor(D/2) cycles of each period. Before the first start, D is 4.
- R4: Number the ticks of a sequence from 0. `sample_stb` pulses together with ticks 0, 2, 4 and 6, and `sample_pair` then reads 0, 1, 2 and 3. Pair p holds channel p of group A and channel p+4 of group B.
- R5: After a pipeline latency of 6 ticks, the results arrive on `conv_data`, one per tick, at ticks 6 to 13. At tick 6+2p the block stores channel p (the A result), and at tick 7+2p it stores channel p+4 (the B result). Channel c appears on `results[14c+13:14c]`.
- R6: `busy` goes low after the capture at tick 13. In the next cycle, `done_irq` pulses for one cycle if `dma_mode` is 0, or `dma_req` pulses if `dma_mode` is 1.
- R7: A stored value of 14'h0000 or 14'h3FFF sets `oor_flags[c]`, and the flag stays set until `flag_clr` is high. `flag_clr` clears all flags. If a flag is set and cleared in the same cycle, the set wins.
- R8: A start event while `busy` is high does not change the running sequence. It sets `overrun`, which stays set until `flag_clr` clears it. If the overrun and the clear fall in the same cycle, the set wins.
- R9: Changing `div_sel` during a sequence does not change the tick spacing of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Start source select |
| sw_start | input | 1 | Software start pulse |
| ext_start | input | 1 | External start pin (rising edge) |
| tmr_evt | input | 1 | Timer start pulse |
| div_sel | input | 5 | Requested clock divisor |
| dma_mode | input | 1 | Send completion to DMA request instead of interrupt |
| flag_clr | input | 1 | Clear out-of-range and overrun flags |
| conv_data | input | 14 | Result bus from the converter |
| adc_clk | output | 1 | Divided converter clock |
| conv_tick | output | 1 | One-cycle converter clock enable |
| sample_stb | output | 1 | Hold command for a channel pair |
| sample_pair | output | 2 | Pair index being held |
| busy | output | 1 | Sequence in progress |
| done_irq | output | 1 | Completion pulse, interrupt mode |
| dma_req | output | 1 | Completion pulse, DMA mode |
| overrun | output | 1 | Sticky start-while-busy flag |
| oor_flags | output | 8 | Sticky out-of-range flags, one per channel |
| results | output | 112 | Eight 14-bit channel results |

## Verification
Two cases put two actions on the same clock edge. In the first, an out-of-range result is captured while the host is clearing the flags. In the second, a start arrives during a sequence in the same cycle as a clear. The bench provokes both by holding `flag_clr` high for a whole sequence whose channel values include both end codes, and by pulsing the timer input during that window. A reference model in the bench follows the rule that the set wins. Each compare checks that a flag reads 1 in the cycle after its capture and 0 one cycle later.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_NONE  = 2'd3
  } start_src_e;

  // Limit a requested divisor to the supported window.
  function automatic int unsigned clamp_div(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Result slot order on the converter bus: even slots are group A,
  // odd slots are group B, two slots per pair.
  function automatic int unsigned slot_to_chan(input int unsigned slot,
                                               input int unsigned pairs);
    return (slot / 2) + ((slot % 2) * pairs);
  endfunction

endpackage

// File: rtl/adcseq_trigger.sv
module adcseq_trigger
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       sw_start,
  input  logic       ext_start,
  input  logic       tmr_evt,
  output logic       start_evt
);

  logic ext_q;
  logic pin_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_start;
  end

  assign pin_rise = ext_start & ~ext_q;

  always_comb begin
    case (start_src_e'(src_sel))
      SRC_SOFT:  start_evt = sw_start;
      SRC_PIN:   start_evt = pin_rise;
      SRC_TIMER: start_evt = tmr_evt;
      default:   start_evt = 1'b0;
    endcase
  end

  // R2: with no source selected, no start event appears
  a_r2_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |-> !start_evt);

endmodule

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv
  import adcseq_pkg::*;
#(
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick,
  output logic             adc_clk
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_LO);
      cnt_q <= '0;
    end else if (restart) begin
      div_q <= DIV_W'(clamp_div(int'(div_sel), DIV_LO, DIV_HI));
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick    = (cnt_q == div_q - 1'b1);
  assign adc_clk = (cnt_q < (div_q >> 1));

  // R3: the divisor stays inside its window
  a_r3_div_window: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= DIV_W'(DIV_LO)) && (div_q <= DIV_W'(DIV_HI)));
  // R3: ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R9: the divisor only moves when a start is accepted
  a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(div_q));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl #(
  parameter int unsigned PAIRS = 4,
  parameter int unsigned LAT   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       start_evt,
  input  logic                       flag_clr,
  input  logic                       dma_mode,
  output logic                       restart,
  output logic                       busy,
  output logic                       sample_stb,
  output logic [$clog2(PAIRS)-1:0]   sample_pair,
  output logic                       cap_en,
  output logic [$clog2(2*PAIRS)-1:0] cap_slot,
  output logic                       done_irq,
  output logic                       dma_req,
  output logic                       overrun
);

  localparam int unsigned SLOTS = 2 * PAIRS;
  localparam int unsigned LAST  = LAT + SLOTS - 1;
  localparam int unsigned KW    = $clog2(LAST + 2);
  localparam int unsigned PW    = $clog2(PAIRS);
  localparam int unsigned SW    = $clog2(SLOTS);

  logic          busy_q;
  logic [KW-1:0] k_q;
  logic          ovr_q;
  logic          done_q;
  logic          dma_q;
  logic          step;
  logic          last_cap;
  logic          overrun_hit;

  assign restart     = start_evt & ~busy_q;
  assign overrun_hit = start_evt & busy_q;
  assign step        = busy_q & tick;
  assign sample_stb  = step & ~k_q[0] & (k_q < KW'(SLOTS));
  assign sample_pair = PW'(k_q >> 1);
  assign cap_en      = step & (k_q >= KW'(LAT)) & (k_q <= KW'(LAST));
  assign cap_slot    = SW'(k_q - KW'(LAT));
  assign last_cap    = step & (k_q == KW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      done_q <= last_cap & ~dma_mode;
      dma_q  <= last_cap & dma_mode;
      if (restart) begin
        busy_q <= 1'b1;
        k_q    <= '0;
      end else if (step) begin
        k_q <= k_q + 1'b1;
        if (last_cap) busy_q <= 1'b0;
      end
      if (overrun_hit)   ovr_q <= 1'b1;
      else if (flag_clr) ovr_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign done_irq = done_q;
  assign dma_req  = dma_q;
  assign overrun  = ovr_q;

  // R8: a start during a sequence always leaves the overrun flag set
  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_hit |=> overrun);
  // R8: the running sequence is not restarted
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_evt && !step) |=> (busy_q && (k_q == $past(k_q))));
  // R6: only one completion line at a time, and only once idle
  a_r6_one_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_irq, dma_req}));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq || dma_req) |-> !busy_q);
  // R4: hold commands only inside a sequence
  a_r4_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy_q);

endmodule

// File: rtl/adcseq_result.sv
module adcseq_result
  import adcseq_pkg::*;
#(
  parameter int unsigned DW    = 14,
  parameter int unsigned PAIRS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [$clog2(2*PAIRS)-1:0] cap_slot,
  input  logic [DW-1:0]              conv_data,
  input  logic                       flag_clr,
  output logic [2*PAIRS*DW-1:0]      results,
  output logic [2*PAIRS-1:0]         oor_flags
);

  localparam int unsigned CH = 2 * PAIRS;
  localparam int unsigned CW = $clog2(CH);

  logic [CW-1:0] ch_idx;
  logic          at_rail;
  logic [CH-1:0] wr_vec;
  logic [CH-1:0] oor_q;

  assign ch_idx  = CW'(slot_to_chan(int'(cap_slot), PAIRS));
  assign at_rail = (conv_data == '0) || (conv_data == '1);

  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic [DW-1:0] res_q;
    assign wr_vec[c] = cap_en && (ch_idx == CW'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q    <= '0;
        oor_q[c] <= 1'b0;
      end else begin
        if (wr_vec[c]) res_q <= conv_data;
        if (wr_vec[c] && at_rail) oor_q[c] <= 1'b1;
        else if (flag_clr)        oor_q[c] <= 1'b0;
      end
    end
    assign results[c*DW +: DW] = res_q;
  end

  assign oor_flags = oor_q;

  // R5: at most one channel register is written per cycle
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  // R7: without a clear, flags only accumulate
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((oor_q & $past(oor_q)) == $past(oor_q)));

endmodule

// File: rtl/adc_pair_sequencer.sv
module adc_pair_sequencer #(
  parameter int unsigned DW     = 14,
  parameter int unsigned PAIRS  = 4,
  parameter int unsigned LAT    = 6,
  parameter int unsigned DIV_W  = 5,
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               src_sel,
  input  logic                     sw_start,
  input  logic                     ext_start,
  input  logic                     tmr_evt,
  input  logic [DIV_W-1:0]         div_sel,
  input  logic                     dma_mode,
  input  logic                     flag_clr,
  input  logic [DW-1:0]            conv_data,
  output logic                     adc_clk,
  output logic                     conv_tick,
  output logic                     sample_stb,
  output logic [$clog2(PAIRS)-1:0] sample_pair,
  output logic                     busy,
  output logic                     done_irq,
  output logic                     dma_req,
  output logic                     overrun,
  output logic [2*PAIRS-1:0]       oor_flags,
  output logic [2*PAIRS*DW-1:0]    results
);

  localparam int unsigned SW = $clog2(2 * PAIRS);

  logic          start_evt;
  logic          restart;
  logic          cap_en;
  logic [SW-1:0] cap_slot;

  adcseq_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .sw_start  (sw_start),
    .ext_start (ext_start),
    .tmr_evt   (tmr_evt),
    .start_evt (start_evt)
  );

  adcseq_clkdiv #(.DIV_W(DIV_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div_sel (div_sel),
    .tick    (conv_tick),
    .adc_clk (adc_clk)
  );

  adcseq_ctrl #(.PAIRS(PAIRS), .LAT(LAT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (conv_tick),
    .start_evt   (start_evt),
    .flag_clr    (flag_clr),
    .dma_mode    (dma_mode),
    .restart     (restart),
    .busy        (busy),
    .sample_stb  (sample_stb),
    .sample_pair (sample_pair),
    .cap_en      (cap_en),
    .cap_slot    (cap_slot),
    .done_irq    (done_irq),
    .dma_req     (dma_req),
    .overrun     (overrun)
  );

  adcseq_result #(.DW(DW), .PAIRS(PAIRS)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .cap_slot  (cap_slot),
    .conv_data (conv_data),
    .flag_clr  (flag_clr),
    .results   (results),
    .oor_flags (oor_flags)
  );

endmodule

// File: tb/test_adc_pair_sequencer.sv
module test_adc_pair_sequencer;
  localparam int NCH = 8;
  localparam int LAT = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        sw_start = 1'b0, ext_start = 1'b0, tmr_evt = 1'b0;
  logic [4:0]  div_sel = 5'd4;
  logic        dma_mode = 1'b0, flag_clr = 1'b0;
  logic [13:0] conv_data = 14'd0;
  logic        adc_clk, conv_tick, sample_stb, busy, done_irq, dma_req, overrun;
  logic [1:0]  sample_pair;
  logic [7:0]  oor_flags;
  logic [111:0] results;

  adc_pair_sequencer i_adc_pair_sequencer (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start),
    .ext_start(ext_start), .tmr_evt(tmr_evt), .div_sel(div_sel),
    .dma_mode(dma_mode), .flag_clr(flag_clr), .conv_data(conv_data),
    .adc_clk(adc_clk), .conv_tick(conv_tick), .sample_stb(sample_stb),
    .sample_pair(sample_pair), .busy(busy), .done_irq(done_irq),
    .dma_req(dma_req), .overrun(overrun), .oor_flags(oor_flags),
    .results(results));

  // behavioural reference state
  int m_busy = 0, m_k = 0, m_cnt = 0, m_div = 4, m_extq = 0;
  int m_ovr = 0, m_done = 0, m_dma = 0;
  int m_res[NCH];
  int m_oor[NCH];
  int hist[LAT+1];
  int analog[NCH];
  int compared = 0, mismatched = 0;

  function automatic int limit_div(int d);
    if (d < 4) return 4;
    if (d > 30) return 30;
    return d;
  endfunction

  task automatic check_all();
    int bad = 0;
    int tk;
    tk = (m_cnt == m_div - 1);
    compared++;
    if (conv_tick !== tk[0] || adc_clk !== (m_cnt < m_div / 2)) begin
      bad = 1;
      $display("FAIL R3/R9 tick/clk got %b/%b exp %0d/%0d", conv_tick, adc_clk, tk, (m_cnt < m_div / 2));
    end
    if (sample_stb !== (m_busy && tk && (m_k % 2 == 0) && m_k < 8) ||
        (sample_stb === 1'b1 && sample_pair !== 2'(m_k / 2))) begin
      bad = 1;
      $display("FAIL R4 stb/pair got %b/%0d exp k=%0d", sample_stb, sample_pair, m_k);
    end
    if (busy !== m_busy[0]) begin
      bad = 1;
      $display("FAIL R2/R6 busy got %b exp %0d", busy, m_busy);
    end
    if (done_irq !== m_done[0] || dma_req !== m_dma[0]) begin
      bad = 1;
      $display("FAIL R6 done/dma got %b/%b exp %0d/%0d", done_irq, dma_req, m_done, m_dma);
    end
    if (overrun !== m_ovr[0]) begin
      bad = 1;
      $display("FAIL R8 overrun got %b exp %0d", overrun, m_ovr);
    end
    for (int c = 0; c < NCH; c++) begin
      if (results[c*14 +: 14] !== 14'(m_res[c])) begin
        bad = 1;
        $display("FAIL R5 ch%0d got %h exp %h", c, results[c*14 +: 14], m_res[c]);
      end
      if (oor_flags[c] !== m_oor[c][0]) begin
        bad = 1;
        $display("FAIL R7 oor ch%0d got %b exp %0d", c, oor_flags[c], m_oor[c]);
      end
    end
    if (bad) mismatched++;
  endtask

  // one clock: converter model, reference update, edge, compare
  task automatic step();
    int tk, evt, last, n_busy, n_k, n_cnt, n_div, n_ovr;
    int n_res[NCH];
    int n_oor[NCH];
    int setf[NCH];
    tk = (m_cnt == m_div - 1);
    if (tk) begin
      for (int i = LAT; i > 0; i--) hist[i] = hist[i-1];
      if (m_busy && m_k < 8) hist[0] = (m_k % 2 == 0) ? analog[m_k / 2] : analog[m_k / 2 + 4];
      else hist[0] = 0;
      conv_data = 14'(hist[LAT]);
    end
    case (src_sel)
      2'd0: evt = sw_start;
      2'd1: evt = ext_start && !m_extq;
      2'd2: evt = tmr_evt;
      default: evt = 0;
    endcase
    n_busy = m_busy; n_k = m_k; n_div = m_div; last = 0;
    for (int c = 0; c < NCH; c++) begin n_res[c] = m_res[c]; setf[c] = 0; end
    if (m_busy && tk) begin
      if (m_k >= LAT && m_k < LAT + NCH) begin
        int slot, ch;
        slot = m_k - LAT;
        ch = (slot % 2 == 1) ? 4 + slot / 2 : slot / 2;
        n_res[ch] = conv_data;
        if (conv_data == 14'h0000 || conv_data == 14'h3FFF) setf[ch] = 1;
      end
      n_k = m_k + 1;
      if (m_k == LAT + NCH - 1) begin n_busy = 0; last = 1; end
    end
    for (int c = 0; c < NCH; c++) n_oor[c] = setf[c] ? 1 : (flag_clr ? 0 : m_oor[c]);
    n_ovr = (evt && m_busy) ? 1 : (flag_clr ? 0 : m_ovr);
    n_cnt = tk ? 0 : m_cnt + 1;
    if (evt && !m_busy) begin
      n_busy = 1; n_k = 0; n_cnt = 0; n_div = limit_div(div_sel);
    end
    @(posedge clk);
    m_busy = n_busy; m_k = n_k; m_cnt = n_cnt; m_div = n_div; m_ovr = n_ovr;
    m_done = last && !dma_mode; m_dma = last && dma_mode; m_extq = ext_start;
    for (int c = 0; c < NCH; c++) begin m_res[c] = n_res[c]; m_oor[c] = n_oor[c]; end
    @(negedge clk);
    check_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_sw();  sw_start = 1'b1; step(); sw_start = 1'b0; endtask
  task automatic pulse_tmr(); tmr_evt = 1'b1; step(); tmr_evt = 1'b0; endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired, no requirement completed");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_res[c] = 0; m_oor[c] = 0; analog[c] = 100 + 37 * c; end
    for (int i = 0; i <= LAT; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (results !== '0 || oor_flags !== '0 || busy !== 1'b0 || overrun !== 1'b0 ||
        done_irq !== 1'b0 || dma_req !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset got res=%h oor=%b busy=%b ovr=%b exp all zero", results, oor_flags, busy, overrun);
    end
    rst_n = 1'b1;
    run(3);

    // R2 software source, R3 divisor 4, R4 pairing, R5 slot order, R6 interrupt
    src_sel = 2'd0; div_sel = 5'd4;
    pulse_sw();
    run(70);

    // R2 pin source; other sources ignored; R3 clamp 31 -> 30; R7 rail codes
    analog[2] = 0; analog[5] = 14'h3FFF;
    src_sel = 2'd1; div_sel = 5'd31;
    pulse_sw(); pulse_tmr(); run(4);
    ext_start = 1'b1; run(2);
    run(440);
    ext_start = 1'b0; run(2);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;    // R7 clear
    run(3);

    // R2 timer, R3 clamp 2 -> 4, R6 DMA, R8 overrun, R9 divisor change ignored
    analog[0] = 14'h3FFF; analog[2] = 55; analog[5] = 0; analog[7] = 14'h3FFF;
    src_sel = 2'd2; div_sel = 5'd2; dma_mode = 1'b1;
    pulse_tmr();
    run(9);
    div_sel = 5'd17;
    pulse_tmr();                                   // R8 overrun
    run(3);
    flag_clr = 1'b1;                               // R7/R8 set against clear
    run(20);
    pulse_tmr();                                   // overrun in a clear cycle
    run(40);
    flag_clr = 1'b0;
    run(5);

    // R2 no source: nothing starts
    src_sel = 2'd3;
    pulse_sw(); pulse_tmr(); ext_start = 1'b1; run(3); ext_start = 1'b0;
    run(10);

    // R3 odd divisor 7, R9 new divisor taken at start
    src_sel = 2'd0; dma_mode = 1'b0; div_sel = 5'd7;
    for (int c = 0; c < NCH; c++) analog[c] = 16383 - 901 * c;
    pulse_sw();
    run(110);

    finish_run();
  end
endmodule